// File: doc/BRIEF.md
# Integration Window Controller

This block decides when a light-measuring front end is integrating. A free-running oscillator supplies a one-clock tick enable. Each tick advances a 16-bit cycle counter. The controller has two families of operating modes, and `ext_mode_i` selects between them.

In the self-timed family, each window lasts a fixed number of ticks, 2^15 by default. A new window begins as soon as the previous one ends. In the host-timed family, one timing command opens a window and the next timing command closes it. The counter saturates rather than wrapping if the host waits too long. The oscillator and its ticks behave the same way in both families; only the way a window is bounded differs.

When a window closes, the controller raises a one-clock done strobe. In that same cycle the captured count appears on `count_o`. The rest of the chip uses the strobe to latch the converted measurement beside this count. Changing the mode family in the middle of a window abandons that window: no done strobe is raised and the count is not captured.

Top module: `integ_window_ctrl`

## Requirements
- R1: While reset is asserted and at its release, `integrate_active_o` is 0, `done_o` is 0 and `count_o` is 0.
- R2: With `ext_mode_i`=0 (self-timed family), a window opens on the first clock edge at which the block is idle and no mode change is pending; the tick on that edge is not counted. `integrate_active_o` is 1 from the following cycle. The window closes on the edge that carries its INT_LEN-th counted tick (default 32768). `done_o` is 1 in the cycle after that edge and `count_o` then reads INT_LEN.
- R3: In the self-timed family the next window begins on the same edge that closes the previous one. `integrate_active_o` stays 1, and the next `done_o` follows exactly INT_LEN counted ticks later.
- R4: Only clock edges with `tick_i`=1 advance the count, in both families. Edges with `tick_i`=0 are not counted, so a gap in the ticks delays the end of a self-timed window by the length of the gap.
- R5: With `ext_mode_i`=1 (host-timed family) and no window open, a one-cycle pulse on `cmd_i` opens a window; the tick on that edge is not counted. `integrate_active_o` is 1 from the next cycle.
- R6: In the host-timed family, a `cmd_i` pulse while a window is open closes it. `done_o` is 1 in the next cycle. `count_o` then equals the number of ticks on the edges after the opening edge, up to and including the closing edge. `integrate_active_o` returns to 0 in that same cycle.
- R7: In the host-timed family the count stops at 0xFFFF (65535) and never wraps.
- R8: In the self-timed family `cmd_i` has no effect: the window stays active and the count and timing of the next `done_o` are unchanged.
- R9: A change of `ext_mode_i` abandons any open window on the next edge: `integrate_active_o` goes to 0 and no `done_o` is raised for that window. The self-timed family then restarts on the following edge, while the host-timed family waits for a command.
- R10: `done_o` is never high in two consecutive cycles. `count_o` holds its value from one capture to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable, one per oscillator cycle |
| ext_mode_i | input | 1 | Mode family: 0 self-timed, 1 host-timed |
| cmd_i | input | 1 | One-clock pulse per received timing command |
| integrate_active_o | output | 1 | A window is open |
| done_o | output | 1 | One-clock strobe at the end of a window |
| count_o | output | CNT_W | Tick count captured at the last window end |

## Verification
All results are registered. `integrate_active_o` changes in the cycle after the edge that opens, closes or abandons a window. `done_o` and `count_o` appear in the cycle after the edge carrying the closing tick or command. The driver counts clock edges from reset release and counts the ticks it applies, then queues each expected capture with the exact cycle in which it is due. The monitor samples on the falling edge. It requires every strobe to match the head of the queue in both cycle and value, and it flags any strobe that arrives when nothing is expected, which is how abandoned windows and ignored commands are checked.

// File: rtl/iw_pkg.sv
package iw_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_START = 2'd1,
    ACT_END   = 2'd2,
    ACT_ABORT = 2'd3
  } win_act_e;
endpackage

// File: rtl/iw_tick_counter.sv
module iw_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // saturating increment; nxt_o is the value including this edge's tick
  always_comb begin
    nxt_o = cnt_q;
    if (tick_i && (cnt_q != CNT_MAX)) nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)); // R7

endmodule

// File: rtl/iw_window_ctrl.sv
module iw_window_ctrl
  import iw_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned INT_LEN = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             cmd_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output win_act_e         act_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INT_LEN - 1);

  logic     mode_q;
  logic     active_q;
  logic     mode_chg;
  win_act_e act;

  assign mode_chg = (ext_mode_i != mode_q);

  always_comb begin
    act = ACT_HOLD;
    if (mode_chg) begin
      act = ACT_ABORT;
    end else if (ext_mode_i) begin
      if (cmd_i) act = active_q ? ACT_END : ACT_START;
    end else begin
      if (!active_q)                             act = ACT_START;
      else if (tick_i && (cnt_i == LAST_CNT))    act = ACT_END;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      mode_q <= ext_mode_i;
      unique case (act)
        ACT_START: active_q <= 1'b1;
        ACT_ABORT: active_q <= 1'b0;
        ACT_END:   active_q <= !ext_mode_i;  // self-timed restarts at once
        default:   active_q <= active_q;
      endcase
    end
  end

  assign act_o    = act;
  assign active_o = active_q;

  AST_INT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && active_q) |-> (cnt_i < CNT_W'(INT_LEN))); // R2

  AST_INT_STAYS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode_i && !mode_q && active_q) |=> active_q); // R3

endmodule

// File: rtl/iw_capture.sv
module iw_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic [CNT_W-1:0] count_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= en_i;
      if (en_i) count_q <= val_i;
    end
  end

  assign count_o = count_q;
  assign done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_q)); // R10

endmodule

// File: rtl/integ_window_ctrl.sv
module integ_window_ctrl
  import iw_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned INT_LEN = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_mode_i,
  input  logic             cmd_i,
  output logic             integrate_active_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             active;
  logic             clr;
  logic             cap_en;
  win_act_e         act;

  iw_window_ctrl #(.CNT_W(CNT_W), .INT_LEN(INT_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .cmd_i      (cmd_i),
    .tick_i     (tick_i),
    .cnt_i      (cnt),
    .act_o      (act),
    .active_o   (active)
  );

  // counter idles at zero outside a window and restarts on every event
  assign clr    = (act != ACT_HOLD) || !active;
  assign cap_en = (act == ACT_END);

  iw_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .nxt_o  (cnt_nxt)
  );

  iw_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cap_en),
    .val_i   (cnt_nxt),
    .count_o (count_o),
    .done_o  (done_o)
  );

  assign integrate_active_o = active;

  AST_DONE_CLOSES_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ext_mode_i) |-> !integrate_active_o); // R6

endmodule

// File: tb/integ_window_ctrl_bench.sv
`timescale 1ns/1ps
module integ_window_ctrl_bench;
  localparam int CNT_W = 16;
  localparam int INT_LEN = 32768;

  typedef struct {
    int    due;
    int    val;
    string req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic ext_mode_i = 1'b0;
  logic cmd_i = 1'b0;
  logic integrate_active_o;
  logic done_o;
  logic [CNT_W-1:0] count_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;
  bit prev_done = 0;
  exp_t expq[$];

  always #2.5 clk_i = ~clk_i;

  integ_window_ctrl #(.CNT_W(CNT_W), .INT_LEN(INT_LEN)) u_integ_window_ctrl (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .tick_i             (tick_i),
    .ext_mode_i         (ext_mode_i),
    .cmd_i              (cmd_i),
    .integrate_active_o (integrate_active_o),
    .done_o             (done_o),
    .count_o            (count_o)
  );

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every strobe must match the queue head in cycle and value
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (done_o) begin
        check("R10 strobe width", int'(prev_done), 0);
        if (expq.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9: unexpected done, got count %0d expected no strobe (cycle %0d)",
                   count_o, cyc);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check({e.req, " done cycle"}, cyc, e.due);
          check({e.req, " count"}, int'(count_o), e.val);
        end
      end
      prev_done = done_o;
    end
  end

  function automatic bit tick_pat(input int pat, input int k);
    case (pat)
      0:       return 1'b1;
      1:       return k[0];
      default: return (k % 3) == 0;
    endcase
  endfunction

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  // host-timed window of n edges after the opening edge
  task automatic ext_window(input int n, input int pat, input string req);
    int ticks = 0;
    cmd_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i);
    cmd_i = 1'b0;
    check("R5 active after start", int'(integrate_active_o), 1);
    for (int k = 1; k <= n; k++) begin
      tick_i = tick_pat(pat, k);
      if (tick_i) ticks++;
      if (k == n) begin
        cmd_i = 1'b1;
        expq.push_back('{cyc + 1, (ticks > 65535) ? 65535 : ticks, req});
      end
      @(negedge clk_i);
    end
    cmd_i = 1'b0; tick_i = 1'b1;
    check("R6 inactive after stop", int'(integrate_active_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 active", int'(integrate_active_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 count", int'(count_o), 0);
    rst_ni = 1'b1;
    check("R1 count at release", int'(count_o), 0);
    // self-timed: open at edge 1, close after INT_LEN ticks
    expq.push_back('{1 + INT_LEN, INT_LEN, "R2"});
    expq.push_back('{1 + 2 * INT_LEN + 10, INT_LEN, "R3 R4"});
    @(negedge clk_i);
    check("R2 active after start", int'(integrate_active_o), 1);
    wait_until(100);
    cmd_i = 1'b1;
    @(negedge clk_i);
    cmd_i = 1'b0;
    check("R8 active with command", int'(integrate_active_o), 1);
    wait_until(INT_LEN + 2);
    check("R3 active across boundary", int'(integrate_active_o), 1);
    wait_until(40000);
    tick_i = 1'b0;
    repeat (10) @(negedge clk_i);
    tick_i = 1'b1;
    wait_until(2 * INT_LEN + 12);
    // switch family: abandon the fresh window
    ext_mode_i = 1'b1;
    @(negedge clk_i);
    check("R9 abort to idle", int'(integrate_active_o), 0);
    repeat (3) @(negedge clk_i);
    check("R5 idle without command", int'(integrate_active_o), 0);
    ext_window(5, 0, "R6");
    repeat (2) @(negedge clk_i);
    ext_window(20, 1, "R4 R6");
    ext_window(9, 2, "R4 R6");
    ext_window(70000, 0, "R7");
    // abort in both directions, no strobe expected
    cmd_i = 1'b1;
    @(negedge clk_i);
    cmd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_mode_i = 1'b0;
    @(negedge clk_i);
    check("R9 abort host window", int'(integrate_active_o), 0);
    @(negedge clk_i);
    check("R9 self-timed restart", int'(integrate_active_o), 1);
    repeat (5) @(negedge clk_i);
    ext_mode_i = 1'b1;
    @(negedge clk_i);
    check("R9 abort self-timed window", int'(integrate_active_o), 0);
    repeat (5) @(negedge clk_i);
    check("R10 count held", int'(count_o), 65535);
    check("R10 pending captures", expq.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion (cycle %0d)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule